// File: doc/BRIEF.md
# Page-Buffered Write Load Controller

This block is a synchronous model of the write path of a parallel, page-mode nonvolatile memory. It watches active-low chip-enable, output-enable and write-enable strobes that have already been sampled into the clock domain. It also watches a 13-bit address and an 8-bit data bus. Each strobe first passes a noise filter that counts clock ticks. A qualified write pulse then deposits one byte into a 64-entry page buffer, and each buffer entry has its own valid flag.

The first byte fixes the page. Further bytes for the same page may follow in any order, and each one must arrive before the load window runs out. When no byte has arrived for the whole window, a self-timed programming period starts. At its end, only the flagged bytes are copied into a behavioural storage array. A busy output covers the span from the first latched byte to the end of programming. Reads behave like a static RAM and are served only while the block is not busy. All time limits are parameters counted in clock ticks.

Top module: `page_wr_ctrl`

## Requirements
- R1: A write pulse is recognised only while the filtered chip-enable (`ce_n`) and write-enable (`we_n`) are both low and the filtered output-enable (`oe_n`) is high. If `oe_n` is low, or either strobe stays high, no byte is latched and `busy` stays 0.
- R2: Each strobe changes its filtered level only after its raw level has differed for `FILT_CYC` consecutive clock samples. A pulse of `FILT_CYC-1` cycles starts no write.
- R3: The byte address is taken when the write pulse starts, which is when the later of `ce_n` or `we_n` falls. The byte data is taken when the pulse ends, which is when the earlier of the two rises. This holds for pulses controlled by `we_n` and for pulses controlled by `ce_n`.
- R4: `busy` is 0 after reset. It rises on the cycle after the first byte is latched and stays 1 until the commit has completed.
- R5: The first byte sets the page to `addr[12:6]`. While loading, a byte whose page bits differ from that page is discarded and does not restart the load window.
- R6: A byte offset (`addr[5:0]`) that is written again within the same load overwrites the value stored earlier for that offset.
- R7: The commit writes only the offsets that were loaded. Every other byte of the page keeps its previous value.
- R8: Loading ends when `BLC_TICKS` cycles pass with no accepted byte. Programming then lasts `WC_TICKS` cycles. `busy` falls `FILT_CYC+BLC_TICKS+WC_TICKS+1` cycles after the raw strobe release of the last accepted byte.
- R9: Write pulses that arrive during programming are ignored. They do not change the array and do not extend programming.
- R10: `dout_vld` is 1 and `dout` carries the stored byte while `ce_n`=0, `oe_n`=0, `we_n`=1 and `busy`=0. Otherwise `dout_vld`=0 and `dout`=0x00.
- R11: The array resets to all zero. It keeps only the low `MEM_PAGE_W` page bits (default `addr[9:6]`), so addresses that differ only in `addr[12:10]` alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Sampled chip-enable, active low |
| oe_n | input | 1 | Sampled output-enable, active low |
| we_n | input | 1 | Sampled write-enable, active low |
| addr | input | 13 | Byte address: page in [12:6], offset in [5:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0x00 when not valid |
| dout_vld | output | 1 | Read data valid |
| busy | output | 1 | A load or programming period is in progress |

## Verification
The assertions check on every cycle that the load and programming counters stay inside their windows, and that programming cannot be cut short. They also check that programming always returns the block to idle, that the page stays fixed for the whole load, and that no read data leaves the block while it is busy. Several behaviours can only be shown by the bench scenarios: rejection of short glitches, address capture at the start of a pulse and data capture at its end, overwriting of a re-loaded offset, and untouched neighbours after a commit. The same holds for the discarded foreign-page byte, ignored writes during programming, and page aliasing. These are checked with directed cases plus random page loads compared against a memory model kept in the bench.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwc_state_e;

    localparam int STB_WE = 0;
    localparam int STB_OE = 1;
    localparam int STB_CE = 2;
    localparam int STB_N  = 3;

    function automatic logic pwc_same_page(input logic [15:0] a, input logic [15:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/pwc_strobe_filter.sv
module pwc_strobe_filter #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic flt_n
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_n <= 1'b1;
            cnt   <= '0;
        end else if (raw_n != flt_n) begin
            if (cnt == CW'(FILT_CYC - 1)) begin
                flt_n <= raw_n;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/pwc_page_buffer.sv
module pwc_page_buffer #(
    parameter int OFFS_W = 6,
    parameter int DATA_W = 8,
    localparam int NB    = 1 << OFFS_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wen,
    input  logic [OFFS_W-1:0]          widx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NB-1:0]              valid,
    output logic [NB-1:0][DATA_W-1:0]  data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else begin
            if (clr) valid <= '0;
            if (wen) valid[widx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wen) data[widx] <= wdata;
    end
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int OFFS_W     = 6,
    parameter int DATA_W     = 8,
    parameter int MEM_PAGE_W = 4,
    localparam int NB        = 1 << OFFS_W,
    localparam int IDX_W     = OFFS_W + MEM_PAGE_W,
    localparam int DEPTH     = 1 << IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit,
    input  logic [MEM_PAGE_W-1:0]      page,
    input  logic [NB-1:0]              valid,
    input  logic [NB-1:0][DATA_W-1:0]  data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
        end else if (commit) begin
            for (int i = 0; i < NB; i++) begin
                if (valid[i]) mem[{page, OFFS_W'(i)}] <= data[i];
            end
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/page_wr_ctrl.sv
module page_wr_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int OFFS_W     = 6,
    parameter int MEM_PAGE_W = 4,
    parameter int FILT_CYC   = 3,
    parameter int BLC_TICKS  = 40,
    parameter int WC_TICKS   = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              busy
);
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int NB     = 1 << OFFS_W;
    localparam int LCNT_W = $clog2(BLC_TICKS);
    localparam int PCNT_W = $clog2(WC_TICKS);
    localparam int IDX_W  = OFFS_W + MEM_PAGE_W;

    // strobe noise filters
    logic [STB_N-1:0] strb_raw, strb_flt;
    assign strb_raw = {ce_n, oe_n, we_n};

    for (genvar g = 0; g < STB_N; g++) begin : g_filt
        pwc_strobe_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw_n (strb_raw[g]),
            .flt_n (strb_flt[g])
        );
    end

    logic ce_f, oe_f, we_f;
    assign ce_f = strb_flt[STB_CE];
    assign oe_f = strb_flt[STB_OE];
    assign we_f = strb_flt[STB_WE];

    // write pulse qualification
    logic wr_act, wr_q, wr_start, byte_stb;
    logic [ADDR_W-1:0] addr_lat;

    assign wr_act   = !ce_f && !we_f && oe_f;
    assign wr_start = wr_act && !wr_q;
    assign byte_stb = wr_q && !wr_act && (ce_f || we_f);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            addr_lat <= '0;
        end else begin
            wr_q <= wr_act;
            if (wr_start) addr_lat <= addr;
        end
    end

    // load / program sequencing
    pwc_state_e         state;
    logic [PAGE_W-1:0]  page_q;
    logic [LCNT_W-1:0]  load_cnt;
    logic [PCNT_W-1:0]  prog_cnt;
    logic               same_pg, accept, first_byte, commit;
    logic [PAGE_W-1:0]  byte_pg;

    assign byte_pg    = addr_lat[ADDR_W-1:OFFS_W];
    assign same_pg    = pwc_same_page(16'(byte_pg), 16'(page_q));
    assign first_byte = byte_stb && (state == ST_IDLE);
    assign accept     = first_byte || (byte_stb && (state == ST_LOAD) && same_pg);
    assign commit     = (state == ST_PROG) && (prog_cnt == PCNT_W'(WC_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            page_q   <= '0;
            load_cnt <= '0;
            prog_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (first_byte) begin
                        state    <= ST_LOAD;
                        page_q   <= byte_pg;
                        load_cnt <= '0;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        load_cnt <= '0;
                    end else if (load_cnt == LCNT_W'(BLC_TICKS - 1)) begin
                        state    <= ST_PROG;
                        prog_cnt <= '0;
                    end else begin
                        load_cnt <= load_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (commit) state <= ST_IDLE;
                    else        prog_cnt <= prog_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // page buffer and storage
    logic [NB-1:0]             buf_valid;
    logic [NB-1:0][DATA_W-1:0] buf_data;
    logic [DATA_W-1:0]         rd_data;

    pwc_page_buffer #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .clr   (first_byte),
        .wen   (accept),
        .widx  (addr_lat[OFFS_W-1:0]),
        .wdata (din),
        .valid (buf_valid),
        .data  (buf_data)
    );

    pwc_array #(.OFFS_W(OFFS_W), .DATA_W(DATA_W), .MEM_PAGE_W(MEM_PAGE_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .page    (page_q[MEM_PAGE_W-1:0]),
        .valid   (buf_valid),
        .data    (buf_data),
        .rd_idx  (addr[IDX_W-1:0]),
        .rd_data (rd_data)
    );

    assign dout_vld = !busy && !ce_n && !oe_n && we_n;
    assign dout     = dout_vld ? rd_data : '0;
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int BLC_TICKS = 40,
    parameter int WC_TICKS  = 100,
    parameter int PAGE_W    = 7,
    parameter int DATA_W    = 8,
    localparam int LCNT_W   = $clog2(BLC_TICKS),
    localparam int PCNT_W   = $clog2(WC_TICKS)
) (
    input logic              clk,
    input logic              rst,
    input pwc_state_e        state,
    input logic [LCNT_W-1:0] load_cnt,
    input logic [PCNT_W-1:0] prog_cnt,
    input logic [PAGE_W-1:0] page_q,
    input logic              busy,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld
);
    AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> (load_cnt <= LCNT_W'(BLC_TICKS - 1))); // R8
    AST_PROG_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG) |-> (prog_cnt <= PCNT_W'(WC_TICKS - 1))); // R8
    AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && prog_cnt != PCNT_W'(WC_TICKS - 1)) |=> (state == ST_PROG)); // R9
    AST_PROG_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && prog_cnt == PCNT_W'(WC_TICKS - 1)) |=> (state == ST_IDLE && !busy)); // R8
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(page_q)); // R5
    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!dout_vld && dout == '0)); // R10
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (state == ST_LOAD && load_cnt == '0)); // R4
endmodule

bind page_wr_ctrl pwc_checker #(
    .BLC_TICKS (BLC_TICKS),
    .WC_TICKS  (WC_TICKS),
    .PAGE_W    (PAGE_W),
    .DATA_W    (DATA_W)
) u_pwc_checker (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .load_cnt (load_cnt),
    .prog_cnt (prog_cnt),
    .page_q   (page_q),
    .busy     (busy),
    .dout     (dout),
    .dout_vld (dout_vld)
);

// File: tb/test_page_wr_ctrl.sv
module test_page_wr_ctrl;
    localparam int FILT  = 3;
    localparam int BLC   = 40;
    localparam int WC    = 100;
    localparam int EXP_T = FILT + BLC + WC + 1;

    logic clk = 1'b0;
    logic rst, ce_n, oe_n, we_n, dout_vld, busy;
    logic [12:0] addr;
    logic [7:0]  din, dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rel_cyc = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [1024];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    page_wr_ctrl #(.FILT_CYC(FILT), .BLC_TICKS(BLC), .WC_TICKS(WC)) i_page_wr_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .busy(busy)
    );

    function automatic int mdl_idx(input logic [12:0] a);
        return int'(a[9:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [12:0] a, input logic [7:0] d, input bit ce_ctl,
                           input int plen, input bit chg, input logic [7:0] d2);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1;
        if (!ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
        repeat (2) @(negedge clk);
        if (!ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            if (chg && i == FILT + 1) begin
                addr = a ^ 13'h1;
                din  = d2;
            end
        end
        if (!ce_ctl) we_n = 1'b1; else ce_n = 1'b1;
        rel_cyc = cyc;
        repeat (FILT + 2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle(output int elapsed);
        int n;
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        elapsed = cyc - rel_cyc;
        if (busy) chk(1'b0, "R8 busy never fell", 1, 0);
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #5;
        chk(dout_vld === 1'b1 && dout === e, tag, int'(dout), int'(e));
    endtask

    task automatic rd_end();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (FILT + 1) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int el;
        int t_first;
        logic [12:0] pg_base;
        void'($urandom(32'h5EED_0C0D));
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #5;
        chk(busy === 1'b0, "R4 busy after reset", int'(busy), 0);
        chk(dout_vld === 1'b0 && dout === 8'h00, "R10 idle output zero", int'(dout), 0);

        rd_chk(13'h0123, 8'h00, "R11 reset contents zero");
        rd_end();

        // R2: glitch shorter than filter
        @(negedge clk);
        addr = 13'h0040; din = 8'h5A; ce_n = 1'b0; oe_n = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        we_n = 1'b1;
        repeat (8) @(negedge clk);
        #5;
        chk(busy === 1'b0, "R2 short pulse ignored", int'(busy), 0);
        ce_n = 1'b1;
        rd_chk(13'h0040, 8'h00, "R2 short pulse wrote nothing");
        rd_end();

        // R1: oe low blocks, ce high blocks
        @(negedge clk);
        addr = 13'h0041; din = 8'hC3; ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (6) @(negedge clk);
        we_n = 1'b1;
        repeat (8) @(negedge clk);
        #5;
        chk(busy === 1'b0, "R1 oe low blocks write", int'(busy), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        we_n = 1'b0;
        repeat (6) @(negedge clk);
        we_n = 1'b1;
        repeat (8) @(negedge clk);
        #5;
        chk(busy === 1'b0, "R1 ce high blocks write", int'(busy), 0);

        // single byte, we-controlled; R3 R4 R7 R8
        wr_byte(13'h0085, 8'h3C, 1'b0, 5, 1'b0, 8'h00);
        exp_mem[mdl_idx(13'h0085)] = 8'h3C;
        #5;
        chk(busy === 1'b1, "R4 busy after first byte", int'(busy), 1);
        wait_idle(el);
        chk(el >= EXP_T - 1 && el <= EXP_T + 1, "R8 busy duration", el, EXP_T);
        rd_chk(13'h0085, 8'h3C, "R3 we-controlled byte stored");
        rd_chk(13'h0084, 8'h00, "R7 lower neighbour untouched");
        rd_chk(13'h0086, 8'h00, "R7 upper neighbour untouched");
        rd_end();

        // R3: address from pulse start, data from pulse end
        wr_byte(13'h00C8, 8'h10, 1'b0, 8, 1'b1, 8'hE7);
        exp_mem[mdl_idx(13'h00C8)] = 8'hE7;
        wait_idle(el);
        rd_chk(13'h00C8, 8'hE7, "R3 data taken at pulse end");
        rd_chk(13'h00C9, 8'h00, "R3 address taken at pulse start");
        rd_end();

        // ce-controlled bytes and overwrite; R3 R6
        wr_byte(13'h0190, 8'hA7, 1'b1, 5, 1'b0, 8'h00);
        wr_byte(13'h0191, 8'h11, 1'b1, 5, 1'b0, 8'h00);
        wr_byte(13'h0191, 8'h22, 1'b0, 5, 1'b0, 8'h00);
        exp_mem[mdl_idx(13'h0190)] = 8'hA7;
        exp_mem[mdl_idx(13'h0191)] = 8'h22;
        wait_idle(el);
        rd_chk(13'h0190, 8'hA7, "R3 ce-controlled byte stored");
        rd_chk(13'h0191, 8'h22, "R6 reload overwrites");
        rd_end();

        // R5: foreign page discarded, window not restarted
        wr_byte(13'h0200, 8'h77, 1'b0, 5, 1'b0, 8'h00);
        t_first = rel_cyc;
        exp_mem[mdl_idx(13'h0200)] = 8'h77;
        wr_byte(13'h0300, 8'h99, 1'b0, 5, 1'b0, 8'h00);
        wait_idle(el);
        el = cyc - t_first;
        chk(el >= EXP_T - 1 && el <= EXP_T + 1, "R5 window not restarted", el, EXP_T);
        rd_chk(13'h0300, 8'h00, "R5 foreign page byte dropped");
        rd_chk(13'h0200, 8'h77, "R5 own page byte kept");
        rd_end();

        // R9 R10 R11: writes during programming, reads while busy, aliasing
        wr_byte(13'h0405, 8'h66, 1'b0, 5, 1'b0, 8'h00);
        exp_mem[mdl_idx(13'h0405)] = 8'h66;
        repeat (BLC + FILT + 10) @(negedge clk);
        #5;
        chk(busy === 1'b1, "R9 in programming", int'(busy), 1);
        @(negedge clk);
        addr = 13'h0405; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #5;
        chk(dout_vld === 1'b0 && dout === 8'h00, "R10 no read while busy", int'(dout), 0);
        rd_end();
        wr_byte(13'h0406, 8'h55, 1'b0, 5, 1'b0, 8'h00);
        wait_idle(el);
        rd_chk(13'h0406, 8'h00, "R9 write during programming ignored");
        rd_chk(13'h0005, 8'h66, "R11 alias of upper page bits");
        rd_end();

        // random page loads checked against model
        for (int p = 0; p < 6; p++) begin
            logic [6:0] pg;
            int nb;
            pg = 7'($urandom % 128);
            nb = (p == 5) ? 64 : 1 + int'($urandom % 8);
            pg_base = {pg, 6'h00};
            for (int b = 0; b < nb; b++) begin
                logic [5:0] off;
                logic [7:0] dv;
                off = (p == 5) ? 6'(63 - b) : 6'($urandom % 64);
                dv  = 8'($urandom);
                wr_byte(pg_base | 13'(off), dv, 1'($urandom % 2), 4 + int'($urandom % 3), 1'b0, 8'h00);
                exp_mem[mdl_idx(pg_base | 13'(off))] = dv;
            end
            wait_idle(el);
            for (int o = 0; o < 64; o++) begin
                logic [12:0] a;
                a = pg_base | 13'(o);
                rd_chk(a, exp_mem[mdl_idx(a)], (p == 5) ? "R6 R7 full page any order" : "R7 random page load");
            end
            rd_end();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule